// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler

This block derives the serial clock of an I2C controller from the system clock. A programmable prescaler first slows the system clock to a module clock ticking once every (prescale + 1) system cycles. A phase counter then holds the serial clock low and then high. Each phase lasts its programmed count plus a fixed padding, measured in module-clock ticks. The padding depends on the prescale value: 7 ticks for prescale 0, 6 ticks for prescale 1, and 5 ticks for any larger value.

The enable input acts as the module reset of the controller. While it is low, the serial clock is released high and every counter sits at zero. The divider settings should be chosen so that the module clock falls between 7 and 12 MHz, and they are meant to be changed while enable is low. Settings changed while the clock runs are captured only when a new full period begins, so a running period is never distorted. Clock stretching and the data path live elsewhere.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `en_i` is low, `scl_o` is 1 from the clock edge after `en_i` is first sampled low, and it stays 1.
- R2: While `rst_ni` is low, `scl_o` is 1. Once `rst_ni` is released with `en_i` high, a full low phase begins at the next clock edge.
- R3: The first clock edge that samples `en_i` high after it was low drives `scl_o` to 0, so every run starts with the low phase.
- R4: A low phase lasts exactly (`low_i` + d) × (`psc_i` + 1) system clock cycles, where d is the phase padding.
- R5: A high phase lasts exactly (`high_i` + d) × (`psc_i` + 1) system clock cycles.
- R6: The padding d is 7 when the captured prescale value is 0.
- R7: The padding d is 6 when the captured prescale value is 1.
- R8: The padding d is 5 when the captured prescale value is 2 or more.
- R9: Changes to `psc_i`, `low_i` or `high_i` during a period have no effect on that period. They take effect at the next low phase that begins after a high phase ends.
- R10: Dropping `en_i` in the middle of a phase aborts it. The next run begins with a complete low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; low holds the generator idle |
| psc_i | input | PSC_W | Prescale value; module clock = clk_i / (psc_i + 1) |
| low_i | input | CNT_W | Low-phase count in module-clock ticks, before padding |
| high_i | input | CNT_W | High-phase count in module-clock ticks, before padding |
| scl_o | output | 1 | Generated serial clock |

## Verification
The bench builds the block with a 4-bit prescale and 6-bit counts, with the prescaler present. These narrow widths keep every period short enough to measure phase lengths cycle by cycle. They also let the bench reach the top prescale value of 15, which exercises the padding of 5, together with prescale values 0 and 1 for the other two paddings. Zero low and high counts show that the padding alone sets the shortest phase. Mid-period changes to the settings, enable drops in a high phase, and a reset during a run cover the capture and restart rules.

// File: rtl/i2c_scl_gen_pkg.sv
package i2c_scl_gen_pkg;

   typedef enum logic [1:0] {
      SG_IDLE = 2'd0,
      SG_LOW  = 2'd1,
      SG_HIGH = 2'd2
   } sg_state_e;

   // Padding, in module-clock ticks, added to each serial-clock phase
   function automatic int unsigned phase_pad(input int unsigned psc);
      if (psc == 0)      return 7;
      else if (psc == 1) return 6;
      else               return 5;
   endfunction

endpackage

// File: rtl/i2c_scl_gen_presc.sv
module i2c_scl_gen_presc #(
   parameter int unsigned PSC_W         = 8,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic             tick_o
);

   generate
      if (HAS_PRESCALER) begin : g_div
         logic [PSC_W-1:0] cnt_q;
         logic             wrap;

         assign wrap   = (cnt_q == psc_i);
         assign tick_o = run_i && wrap;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      cnt_q <= '0;
            else if (!run_i)  cnt_q <= '0;
            else if (wrap)    cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_bypass
         logic unused_psc;
         assign unused_psc = ^{psc_i, clk_i, rst_ni};
         assign tick_o     = run_i;
      end
   endgenerate

endmodule

// File: rtl/i2c_scl_gen_phase.sv
module i2c_scl_gen_phase #(
   parameter int unsigned CNT_W = 8,
   localparam int unsigned LIM_W = CNT_W + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [LIM_W-1:0] limit_i,
   output logic             done_o
);

   logic [LIM_W-1:0] cnt_q;

   assign done_o = tick_i && (cnt_q == limit_i - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (!run_i)  cnt_q <= '0;
      else if (done_o)  cnt_q <= '0;
      else if (tick_i)  cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
   import i2c_scl_gen_pkg::*;
#(
   parameter int unsigned PSC_W         = 8,
   parameter int unsigned CNT_W         = 8,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [PSC_W-1:0] psc_i,
   input  logic [CNT_W-1:0] low_i,
   input  logic [CNT_W-1:0] high_i,
   output logic             scl_o
);

   localparam int unsigned LIM_W = CNT_W + 1;

   generate
      if (PSC_W < 2) begin : g_bad_psc
         $error("i2c_scl_gen: PSC_W must be at least 2");
      end
      if (CNT_W < 3) begin : g_bad_cnt
         $error("i2c_scl_gen: CNT_W must be at least 3");
      end
   endgenerate

   sg_state_e        state_q;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] low_q;
   logic [CNT_W-1:0] high_q;
   logic [PSC_W-1:0] psc_eff;
   logic             active;
   logic             run;
   logic             tick;
   logic             phase_done;
   logic [LIM_W-1:0] pad;
   logic [LIM_W-1:0] limit;

   assign psc_eff = HAS_PRESCALER ? psc_q : '0;
   assign active  = (state_q != SG_IDLE);
   assign run     = active && en_i;
   assign pad     = LIM_W'(phase_pad(int'(psc_eff)));
   assign limit   = (state_q == SG_HIGH) ? ({1'b0, high_q} + pad)
                                         : ({1'b0, low_q}  + pad);
   assign scl_o   = (state_q != SG_LOW);

   i2c_scl_gen_presc #(
      .PSC_W        (PSC_W),
      .HAS_PRESCALER(HAS_PRESCALER)
   ) u_presc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run),
      .psc_i (psc_eff),
      .tick_o(tick)
   );

   i2c_scl_gen_phase #(
      .CNT_W(CNT_W)
   ) u_phase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .tick_i (tick),
      .limit_i(limit),
      .done_o (phase_done)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SG_IDLE;
         psc_q   <= '0;
         low_q   <= '0;
         high_q  <= '0;
      end else if (!en_i) begin
         state_q <= SG_IDLE;
      end else begin
         unique case (state_q)
            SG_IDLE: begin
               psc_q   <= psc_i;
               low_q   <= low_i;
               high_q  <= high_i;
               state_q <= SG_LOW;
            end
            SG_LOW: begin
               if (phase_done) state_q <= SG_HIGH;
            end
            SG_HIGH: begin
               if (phase_done) begin
                  psc_q   <= psc_i;
                  low_q   <= low_i;
                  high_q  <= high_i;
                  state_q <= SG_LOW;
               end
            end
            default: state_q <= SG_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
   parameter int unsigned PSC_W = 8,
   parameter int unsigned CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic             scl_o,
   input logic             active,
   input logic             tick,
   input logic             phase_done,
   input logic [PSC_W-1:0] psc_q,
   input logic [CNT_W-1:0] low_q,
   input logic [CNT_W-1:0] high_q
);

   assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> scl_o);

   assert_reset_high_R2: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> scl_o);

   assert_low_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !$past(en_i)) |=> !scl_o);

   // R4 and R5: the clock edges only move on a module-clock tick
   assert_edge_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && en_i && !tick) |=> $stable(scl_o));

   assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && en_i && !(phase_done && scl_o))
         |=> ($stable(low_q) && $stable(high_q) && $stable(psc_q)));

   assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && !en_i) |=> (!active && scl_o));

endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(
   .PSC_W(PSC_W),
   .CNT_W(CNT_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .en_i      (en_i),
   .scl_o     (scl_o),
   .active    (active),
   .tick      (tick),
   .phase_done(phase_done),
   .psc_q     (psc_q),
   .low_q     (low_q),
   .high_q    (high_q)
);

// File: tb/i2c_scl_gen_bench.sv
module i2c_scl_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int PSC_W      = 4;
   localparam int CNT_W      = 6;
   localparam int NVEC       = 6;
   localparam int WATCHDOG   = 150000;

   // columns: prescale, low count, high count
   localparam int VEC [NVEC][3] = '{
      '{0,  0, 0},
      '{0,  3, 5},
      '{1,  2, 4},
      '{2,  1, 1},
      '{3,  5, 2},
      '{15, 0, 1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [PSC_W-1:0] psc = '0;
   logic [CNT_W-1:0] lo = '0;
   logic [CNT_W-1:0] hi = '0;
   logic             scl;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_scl_gen #(
      .PSC_W(PSC_W),
      .CNT_W(CNT_W),
      .HAS_PRESCALER(1'b1)
   ) u_i2c_scl_gen (
      .clk_i (clk),
      .rst_ni(rst_n),
      .en_i  (en),
      .psc_i (psc),
      .low_i (lo),
      .high_i(hi),
      .scl_o (scl)
   );

   function automatic int pad_of(input int p);
      return (p == 0) ? 7 : (p == 1) ? 6 : 5;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Called at a falling edge; counts falling edges while scl holds lvl
   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (scl === lvl) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int n;
      int m;
      string dreq;

      // reset state
      repeat (3) @(negedge clk);
      check("R2 scl high in reset", int'(scl), 1);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 scl high while disabled", int'(scl), 1);

      // table of settings
      for (int i = 0; i < NVEC; i++) begin
         en  = 1'b0;
         psc = PSC_W'(VEC[i][0]);
         lo  = CNT_W'(VEC[i][1]);
         hi  = CNT_W'(VEC[i][2]);
         repeat (3) @(negedge clk);
         en = 1'b1;
         @(negedge clk);
         dreq = (VEC[i][0] == 0) ? "R6" : (VEC[i][0] == 1) ? "R7" : "R8";
         check("R3 first phase low", int'(scl), 0);
         run_len(1'b0, n);
         check($sformatf("R4 %s low phase vec %0d", dreq, i), n,
               (VEC[i][1] + pad_of(VEC[i][0])) * (VEC[i][0] + 1));
         run_len(1'b1, n);
         check($sformatf("R5 %s high phase vec %0d", dreq, i), n,
               (VEC[i][2] + pad_of(VEC[i][0])) * (VEC[i][0] + 1));
         run_len(1'b0, n);
         check($sformatf("R4 second low phase vec %0d", i), n,
               (VEC[i][1] + pad_of(VEC[i][0])) * (VEC[i][0] + 1));
         @(negedge clk);
      end

      // R9: settings changed mid-period wait for the next period
      en  = 1'b0;
      psc = '0;
      lo  = CNT_W'(4);
      hi  = CNT_W'(4);
      repeat (3) @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      n = 0;
      repeat (3) begin
         if (scl === 1'b0) n++;
         @(negedge clk);
      end
      lo = CNT_W'(10);
      hi = CNT_W'(2);
      run_len(1'b0, m);
      check("R9 low unchanged", n + m, 11);
      run_len(1'b1, n);
      check("R9 high unchanged", n, 11);
      run_len(1'b0, n);
      check("R9 new low applied", n, 17);
      run_len(1'b1, n);
      check("R9 new high applied", n, 9);

      // R10: abort in the high phase
      repeat (2) @(negedge clk);
      run_len(1'b0, n);
      repeat (2) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R10 abort releases scl", int'(scl), 1);
      repeat (5) @(negedge clk);
      check("R1 stays high after abort", int'(scl), 1);
      en = 1'b1;
      @(negedge clk);
      run_len(1'b0, n);
      check("R10 full low after restart", n, 17);

      // R2: reset in the middle of a run
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R2 scl high under reset", int'(scl), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 low phase after reset release", int'(scl), 0);
      run_len(1'b0, n);
      check("R2 full low after reset", n, 17);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule